// File: doc/BRIEF.md
# Trap Handler Vector Selector

This block decides where a trap is delivered and where execution resumes. It takes a snapshot of the processor state: the RED flag, the hyper-privilege and privilege flags, the current trap level, the requested trap type, and the two trap-base registers. From these it picks one of four delivery modes: RED, error, hyper or privileged. For every mode except error it also produces the trap type actually used for vectoring, the new trap level, and the handler PC together with the two sequential fetch addresses that follow it.

A trap request is a single-cycle pulse on `trap_vld`. By default the result is registered and appears on the outputs one clock later. The outputs then hold until the next request. The state-saving logic that sits next to this block reads `out_mode` and `out_tl` to learn what to push. A parameter selects a purely combinational variant instead.

Top module: `trapvec_sel`

## Requirements
- R1: The current level is hyper when `st_hpriv` is 1, privileged when only `st_priv` is 1, and user otherwise. The target level is one above the current level, capped at hyper. A user trap at trap level 0 with a trap type below 384 is delivered in privileged mode (`out_mode` = 0). A privileged or hyper trap under the same conditions is delivered in hyper mode (`out_mode` = 1).
- R2: When `st_red` is 1, or `cur_tl` equals MAX_TL-1, the mode is RED (`out_mode` = 2) and `out_tt` is 5. This check has the highest priority.
- R3: When R2 does not apply and `cur_tl` is MAX_TL or more, the mode is error (`out_mode` = 3). `out_tt` carries the incoming type, `out_tl` carries `cur_tl`, and all three addresses are zero.
- R4: When neither R2 nor R3 applies, the target is privileged and `cur_tl` exceeds MAX_PTL, the mode is hyper and `out_tt` is 2.
- R5: Otherwise, a hyper target, or a privileged target with trap type 384 or above, gives hyper mode with `out_tt` equal to `trap_tt`. Every remaining case gives privileged mode with `out_tt` equal to `trap_tt`.
- R6: The RED handler PC is 0xFFF0000000 ORed with bits [7:0] of (`out_tt` << 5).
- R7: The hyper handler PC is `hyp_base` with bits [13:0] replaced by bits [13:0] of (`out_tt` << 5).
- R8: The privileged handler PC is `priv_base` with bits [14:0] cleared. Bit 14 is then set when `out_tl` exceeds 1, and the result is ORed with bits [13:0] of (`out_tt` << 5).
- R9: Outside error mode, `out_npc` = `out_pc` + 4 and `out_nnpc` = `out_pc` + 8.
- R10: Outside error mode, `out_tl` is `cur_tl` + 1, capped at MAX_TL.
- R11: With OUT_REG = 1, `out_vld` is 1 in exactly the cycle after a request. All outputs hold their values while `trap_vld` is 0, and are zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_vld | input | 1 | Trap request pulse |
| st_red | input | 1 | RED state flag |
| st_hpriv | input | 1 | Hyper-privileged flag |
| st_priv | input | 1 | Privileged flag |
| cur_tl | input | TL_W | Trap level before the trap |
| trap_tt | input | TT_W | Requested trap type |
| hyp_base | input | ADDR_W | Hyper trap-base register |
| priv_base | input | ADDR_W | Privileged trap-base register |
| out_vld | output | 1 | Result valid |
| out_mode | output | 2 | 0 privileged, 1 hyper, 2 RED, 3 error |
| out_tt | output | TT_W | Effective trap type |
| out_tl | output | TL_W | New trap level |
| out_pc | output | ADDR_W | Handler PC |
| out_npc | output | ADDR_W | Handler PC + 4 |
| out_nnpc | output | ADDR_W | Handler PC + 8 |

## Verification
The assertions assume that `trap_vld` is a pulse lasting at most one cycle. They also assume the base registers stay stable for the cycle in which a request is registered, so that the registered PC can be related to the base sampled one cycle earlier. The stimulus drives every request for a single cycle and changes inputs only on the falling clock edge. It draws trap levels across the whole TL_W range, so the RED, error and guest-watchdog thresholds are all crossed. Trap types are drawn around the 384 boundary, and all combinations of the three state flags occur.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;

   typedef enum logic [1:0] {
      TV_PRIV = 2'd0,
      TV_HYP  = 2'd1,
      TV_RED  = 2'd2,
      TV_ERR  = 2'd3
   } tv_mode_e;

   typedef enum logic [1:0] {
      LV_USER = 2'd0,
      LV_PRIV = 2'd1,
      LV_HYP  = 2'd2
   } tv_lvl_e;

   function automatic tv_lvl_e tv_next_lvl(input tv_lvl_e cur);
      case (cur)
         LV_USER: tv_next_lvl = LV_PRIV;
         default: tv_next_lvl = LV_HYP;
      endcase
   endfunction

endpackage

// File: rtl/trapvec_lvl_dec.sv
module trapvec_lvl_dec
   import trapvec_pkg::*;
(
   input  logic    st_hpriv,
   input  logic    st_priv,
   output tv_lvl_e cur_lvl,
   output tv_lvl_e tgt_lvl
);

   always_comb begin
      if (st_hpriv)     cur_lvl = LV_HYP;
      else if (st_priv) cur_lvl = LV_PRIV;
      else              cur_lvl = LV_USER;
      tgt_lvl = tv_next_lvl(cur_lvl);
   end

endmodule

// File: rtl/trapvec_route.sv
module trapvec_route
   import trapvec_pkg::*;
#(
   parameter int TL_W       = 3,
   parameter int TT_W       = 9,
   parameter int MAX_TL     = 6,
   parameter int MAX_PTL    = 2,
   parameter int HYP_TT_MIN = 384,
   parameter int RED_TT     = 5,
   parameter int GWD_TT     = 2
) (
   input  logic            st_red,
   input  tv_lvl_e         tgt_lvl,
   input  logic [TL_W-1:0] cur_tl,
   input  logic [TT_W-1:0] trap_tt,
   output tv_mode_e        mode,
   output logic [TT_W-1:0] eff_tt,
   output logic [TL_W-1:0] eff_tl
);

   localparam logic [TL_W-1:0] TL_MAX   = TL_W'(MAX_TL);
   localparam logic [TL_W-1:0] TL_RED   = TL_W'(MAX_TL - 1);
   localparam logic [TL_W-1:0] TL_PMAX  = TL_W'(MAX_PTL);
   localparam logic [TT_W-1:0] TT_HMIN  = TT_W'(HYP_TT_MIN);

   logic            at_red_lvl;
   logic            at_err_lvl;
   logic            guest_wd;
   logic            to_hyp;
   logic [TL_W-1:0] tl_inc;

   always_comb begin
      at_red_lvl = (cur_tl == TL_RED);
      at_err_lvl = (cur_tl >= TL_MAX);
      guest_wd   = (cur_tl > TL_PMAX) && (tgt_lvl == LV_PRIV);
      to_hyp     = (tgt_lvl == LV_HYP) || (trap_tt >= TT_HMIN);
      tl_inc     = at_err_lvl ? TL_MAX : (cur_tl + TL_W'(1));
   end

   always_comb begin
      mode   = TV_PRIV;
      eff_tt = trap_tt;
      eff_tl = tl_inc;
      if (st_red || at_red_lvl) begin
         mode   = TV_RED;
         eff_tt = TT_W'(RED_TT);
      end else if (at_err_lvl) begin
         mode   = TV_ERR;
         eff_tl = cur_tl;
      end else if (guest_wd) begin
         mode   = TV_HYP;
         eff_tt = TT_W'(GWD_TT);
      end else if (to_hyp) begin
         mode   = TV_HYP;
      end
   end

endmodule

// File: rtl/trapvec_addr_gen.sv
module trapvec_addr_gen
   import trapvec_pkg::*;
#(
   parameter int              ADDR_W     = 64,
   parameter int              TL_W       = 3,
   parameter int              TT_W       = 9,
   parameter int              VEC_SHIFT  = 5,
   parameter int              RED_OFF_W  = 8,
   parameter int              HYP_ALIGN  = 14,
   parameter int              PRIV_ALIGN = 15,
   parameter int              INSN_BYTES = 4,
   parameter logic [ADDR_W-1:0] RED_BASE = ADDR_W'(64'h0000_00FF_F000_0000)
) (
   input  tv_mode_e          mode,
   input  logic [TT_W-1:0]   eff_tt,
   input  logic [TL_W-1:0]   eff_tl,
   input  logic [ADDR_W-1:0] hyp_base,
   input  logic [ADDR_W-1:0] priv_base,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] npc,
   output logic [ADDR_W-1:0] nnpc
);

   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] RED_MASK  = (ONE << RED_OFF_W) - ONE;
   localparam logic [ADDR_W-1:0] HYP_MASK  = (ONE << HYP_ALIGN) - ONE;
   localparam logic [ADDR_W-1:0] PRIV_MASK = (ONE << PRIV_ALIGN) - ONE;
   localparam logic [ADDR_W-1:0] LVL_BIT   = ONE << HYP_ALIGN;
   localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(INSN_BYTES);

   logic [ADDR_W-1:0] tt_off;
   logic [ADDR_W-1:0] red_pc;
   logic [ADDR_W-1:0] hyp_pc;
   logic [ADDR_W-1:0] priv_pc;
   logic              deep;

   always_comb begin
      tt_off  = ADDR_W'(eff_tt) << VEC_SHIFT;
      deep    = (eff_tl > TL_W'(1));
      red_pc  = RED_BASE | (tt_off & RED_MASK);
      hyp_pc  = (hyp_base & ~HYP_MASK) | (tt_off & HYP_MASK);
      priv_pc = (priv_base & ~PRIV_MASK) | (deep ? LVL_BIT : '0)
              | (tt_off & HYP_MASK);
   end

   always_comb begin
      case (mode)
         TV_RED:  pc = red_pc;
         TV_HYP:  pc = hyp_pc;
         TV_PRIV: pc = priv_pc;
         default: pc = '0;
      endcase
      if (mode == TV_ERR) begin
         npc  = '0;
         nnpc = '0;
      end else begin
         npc  = pc + STEP;
         nnpc = pc + (STEP << 1);
      end
   end

endmodule

// File: rtl/trapvec_sel.sv
module trapvec_sel
   import trapvec_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int TL_W       = 3,
   parameter int TT_W       = 9,
   parameter int MAX_TL     = 6,
   parameter int MAX_PTL    = 2,
   parameter int HYP_TT_MIN = 384,
   parameter int VEC_SHIFT  = 5,
   parameter int HYP_ALIGN  = 14,
   parameter int PRIV_ALIGN = 15,
   parameter int INSN_BYTES = 4,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_vld,
   input  logic              st_red,
   input  logic              st_hpriv,
   input  logic              st_priv,
   input  logic [TL_W-1:0]   cur_tl,
   input  logic [TT_W-1:0]   trap_tt,
   input  logic [ADDR_W-1:0] hyp_base,
   input  logic [ADDR_W-1:0] priv_base,
   output logic              out_vld,
   output logic [1:0]        out_mode,
   output logic [TT_W-1:0]   out_tt,
   output logic [TL_W-1:0]   out_tl,
   output logic [ADDR_W-1:0] out_pc,
   output logic [ADDR_W-1:0] out_npc,
   output logic [ADDR_W-1:0] out_nnpc
);

   if (MAX_TL >= (1 << TL_W)) begin : g_bad_tl_w
      $error("trapvec_sel: MAX_TL does not fit in TL_W");
   end
   if (MAX_PTL >= MAX_TL - 1) begin : g_bad_ptl
      $error("trapvec_sel: MAX_PTL must lie below the RED level");
   end
   if (PRIV_ALIGN != HYP_ALIGN + 1) begin : g_bad_align
      $error("trapvec_sel: PRIV_ALIGN must be HYP_ALIGN + 1");
   end
   if (ADDR_W <= PRIV_ALIGN) begin : g_bad_addr_w
      $error("trapvec_sel: ADDR_W too small for the base alignment");
   end

   tv_lvl_e           cur_lvl;
   tv_lvl_e           tgt_lvl;
   tv_mode_e          nxt_mode;
   logic [TT_W-1:0]   nxt_tt;
   logic [TL_W-1:0]   nxt_tl;
   logic [ADDR_W-1:0] nxt_pc;
   logic [ADDR_W-1:0] nxt_npc;
   logic [ADDR_W-1:0] nxt_nnpc;

   trapvec_lvl_dec u_lvl (
      .st_hpriv (st_hpriv),
      .st_priv  (st_priv),
      .cur_lvl  (cur_lvl),
      .tgt_lvl  (tgt_lvl)
   );

   trapvec_route #(
      .TL_W       (TL_W),
      .TT_W       (TT_W),
      .MAX_TL     (MAX_TL),
      .MAX_PTL    (MAX_PTL),
      .HYP_TT_MIN (HYP_TT_MIN)
   ) u_route (
      .st_red  (st_red),
      .tgt_lvl (tgt_lvl),
      .cur_tl  (cur_tl),
      .trap_tt (trap_tt),
      .mode    (nxt_mode),
      .eff_tt  (nxt_tt),
      .eff_tl  (nxt_tl)
   );

   trapvec_addr_gen #(
      .ADDR_W     (ADDR_W),
      .TL_W       (TL_W),
      .TT_W       (TT_W),
      .VEC_SHIFT  (VEC_SHIFT),
      .HYP_ALIGN  (HYP_ALIGN),
      .PRIV_ALIGN (PRIV_ALIGN),
      .INSN_BYTES (INSN_BYTES)
   ) u_addr (
      .mode      (nxt_mode),
      .eff_tt    (nxt_tt),
      .eff_tl    (nxt_tl),
      .hyp_base  (hyp_base),
      .priv_base (priv_base),
      .pc        (nxt_pc),
      .npc       (nxt_npc),
      .nnpc      (nxt_nnpc)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_vld  <= 1'b0;
            out_mode <= '0;
            out_tt   <= '0;
            out_tl   <= '0;
            out_pc   <= '0;
            out_npc  <= '0;
            out_nnpc <= '0;
         end else begin
            out_vld <= trap_vld;
            if (trap_vld) begin
               out_mode <= nxt_mode;
               out_tt   <= nxt_tt;
               out_tl   <= nxt_tl;
               out_pc   <= nxt_pc;
               out_npc  <= nxt_npc;
               out_nnpc <= nxt_nnpc;
            end
         end
      end
   end else begin : g_comb
      always_comb begin
         out_vld  = trap_vld;
         out_mode = nxt_mode;
         out_tt   = nxt_tt;
         out_tl   = nxt_tl;
         out_pc   = nxt_pc;
         out_npc  = nxt_npc;
         out_nnpc = nxt_nnpc;
      end
   end

endmodule

// File: rtl/trapvec_sel_chk.sv
module trapvec_sel_chk #(
   parameter int ADDR_W     = 64,
   parameter int TL_W       = 3,
   parameter int TT_W       = 9,
   parameter int MAX_TL     = 6,
   parameter int MAX_PTL    = 2,
   parameter int HYP_ALIGN  = 14,
   parameter int INSN_BYTES = 4,
   parameter bit OUT_REG    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trap_vld,
   input logic              st_red,
   input logic              st_hpriv,
   input logic              st_priv,
   input logic [TL_W-1:0]   cur_tl,
   input logic [ADDR_W-1:0] hyp_base,
   input logic              out_vld,
   input logic [1:0]        out_mode,
   input logic [TT_W-1:0]   out_tt,
   input logic [TL_W-1:0]   out_tl,
   input logic [ADDR_W-1:0] out_pc,
   input logic [ADDR_W-1:0] out_npc,
   input logic [ADDR_W-1:0] out_nnpc
);

   localparam logic [ADDR_W-1:0] HMASK = (ADDR_W'(1) << HYP_ALIGN) - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSN_BYTES);

   AST_ERR_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_mode == 2'd3) |-> (out_pc == '0 && out_npc == '0 && out_nnpc == '0)); // R3

   AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_mode != 2'd3) |-> (out_npc == out_pc + STEP && out_nnpc == out_npc + STEP)); // R9

   AST_PRIV_DEPTH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_mode == 2'd0) |-> (out_pc[HYP_ALIGN] == (out_tl > TL_W'(1)))); // R8

   if (OUT_REG) begin : g_seq
      AST_RED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
         (trap_vld && st_red) |=> (out_vld && out_mode == 2'd2 && out_tt == TT_W'(5))); // R2

      AST_GUEST_WD: assert property (@(posedge clk) disable iff (!rst_n)
         (trap_vld && !st_red && !st_hpriv && !st_priv && cur_tl > TL_W'(MAX_PTL)
          && cur_tl < TL_W'(MAX_TL - 1)) |=> (out_mode == 2'd1 && out_tt == TT_W'(2))); // R4

      AST_HYP_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (out_vld && out_mode == 2'd1) |-> ((out_pc & ~HMASK) == ($past(hyp_base) & ~HMASK))); // R7

      AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         trap_vld |=> out_vld); // R11

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !trap_vld |=> ($stable(out_pc) && $stable(out_mode) && $stable(out_tl))); // R11
   end

endmodule

bind trapvec_sel trapvec_sel_chk #(
   .ADDR_W     (ADDR_W),
   .TL_W       (TL_W),
   .TT_W       (TT_W),
   .MAX_TL     (MAX_TL),
   .MAX_PTL    (MAX_PTL),
   .HYP_ALIGN  (HYP_ALIGN),
   .INSN_BYTES (INSN_BYTES),
   .OUT_REG    (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trap_vld  (trap_vld),
   .st_red    (st_red),
   .st_hpriv  (st_hpriv),
   .st_priv   (st_priv),
   .cur_tl    (cur_tl),
   .hyp_base  (hyp_base),
   .out_vld   (out_vld),
   .out_mode  (out_mode),
   .out_tt    (out_tt),
   .out_tl    (out_tl),
   .out_pc    (out_pc),
   .out_npc   (out_npc),
   .out_nnpc  (out_nnpc)
);

// File: tb/trapvec_sel_tb_top.sv
module trapvec_sel_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_vld = 1'b0;
   logic        st_red = 1'b0;
   logic        st_hpriv = 1'b0;
   logic        st_priv = 1'b0;
   logic [2:0]  cur_tl = '0;
   logic [8:0]  trap_tt = '0;
   logic [63:0] hyp_base = '0;
   logic [63:0] priv_base = '0;
   logic        out_vld;
   logic [1:0]  out_mode;
   logic [8:0]  out_tt;
   logic [2:0]  out_tl;
   logic [63:0] out_pc;
   logic [63:0] out_npc;
   logic [63:0] out_nnpc;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   trapvec_sel dut_i (
      .clk (clk), .rst_n (rst_n), .trap_vld (trap_vld),
      .st_red (st_red), .st_hpriv (st_hpriv), .st_priv (st_priv),
      .cur_tl (cur_tl), .trap_tt (trap_tt),
      .hyp_base (hyp_base), .priv_base (priv_base),
      .out_vld (out_vld), .out_mode (out_mode), .out_tt (out_tt),
      .out_tl (out_tl), .out_pc (out_pc), .out_npc (out_npc),
      .out_nnpc (out_nnpc)
   );

   logic [1:0]  e_mode;
   logic [8:0]  e_tt;
   logic [2:0]  e_tl;
   logic [63:0] e_pc;
   logic [63:0] e_npc;
   logic [63:0] e_nnpc;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Bench model built from the requirements (MAX_TL=6, MAX_PTL=2)
   task automatic model(input logic red, input logic hp, input logic pv,
                        input logic [2:0] tl, input logic [8:0] tt,
                        input logic [63:0] hb, input logic [63:0] pb);
      logic        tgt_hyp;
      logic [13:0] off;
      tgt_hyp = hp | pv;                                  // R1
      e_tl    = (tl >= 3'd6) ? 3'd6 : tl + 3'd1;          // R10
      e_tt    = tt;
      if (red || tl == 3'd5) begin                        // R2
         e_mode = 2'd2; e_tt = 9'd5;
      end else if (tl >= 3'd6) begin                      // R3
         e_mode = 2'd3; e_tl = tl;
      end else if (tl > 3'd2 && !tgt_hyp) begin           // R4
         e_mode = 2'd1; e_tt = 9'd2;
      end else if (tgt_hyp || tt >= 9'd384) begin         // R5
         e_mode = 2'd1;
      end else begin
         e_mode = 2'd0;
      end
      off = 14'({e_tt, 5'b0});
      case (e_mode)
         2'd2: e_pc = 64'h00FF_F000_0000 | {56'b0, off[7:0]};      // R6
         2'd1: e_pc = {hb[63:14], off};                            // R7
         2'd0: e_pc = {pb[63:15], (e_tl > 3'd1), off};             // R8
         default: e_pc = '0;
      endcase
      e_npc  = (e_mode == 2'd3) ? '0 : e_pc + 64'd4;                // R9
      e_nnpc = (e_mode == 2'd3) ? '0 : e_pc + 64'd8;
   endtask

   task automatic compare_all();
      string tt_tag;
      string pc_tag;
      if (e_mode == 2'd2)      tt_tag = "R2";
      else if (e_mode == 2'd3) tt_tag = "R3";
      else if (e_tt == 9'd2 && trap_tt != 9'd2) tt_tag = "R4";
      else                     tt_tag = "R5";
      case (e_mode)
         2'd2: pc_tag = "R6";
         2'd1: pc_tag = "R7";
         2'd0: pc_tag = "R8";
         default: pc_tag = "R3";
      endcase
      chk("R11 vld", {63'b0, out_vld}, 64'd1);
      chk("R1 mode", {62'b0, out_mode}, {62'b0, e_mode});
      chk({tt_tag, " tt"}, {55'b0, out_tt}, {55'b0, e_tt});
      chk("R10 tl", {61'b0, out_tl}, {61'b0, e_tl});
      chk({pc_tag, " pc"}, out_pc, e_pc);
      chk("R9 npc", out_npc, e_npc);
      chk("R9 nnpc", out_nnpc, e_nnpc);
   endtask

   task automatic apply(input logic red, input logic hp, input logic pv,
                        input logic [2:0] tl, input logic [8:0] tt,
                        input logic [63:0] hb, input logic [63:0] pb);
      @(negedge clk);
      st_red = red; st_hpriv = hp; st_priv = pv;
      cur_tl = tl; trap_tt = tt; hyp_base = hb; priv_base = pb;
      trap_vld = 1'b1;
      model(red, hp, pv, tl, tt, hb, pb);
      @(negedge clk);
      trap_vld = 1'b0;
      compare_all();
   endtask

   localparam logic [63:0] HB = 64'h0000_1234_5678_FFFF;
   localparam logic [63:0] PB = 64'h0000_0ABC_DEF0_7FFF;

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      chk("R11 reset vld", {63'b0, out_vld}, 64'd0);
      chk("R11 reset pc", out_pc, 64'd0);
      rst_n = 1'b1;

      apply(0, 0, 0, 3'd0, 9'h041, HB, PB);   // R1 user -> privileged, R8 bit14 clear
      apply(0, 0, 1, 3'd0, 9'h041, HB, PB);   // R1 privileged -> hyper
      apply(0, 1, 0, 3'd1, 9'h010, HB, PB);   // R1 hyper -> hyper
      apply(0, 0, 0, 3'd1, 9'h07F, HB, PB);   // R8 bit14 set
      apply(0, 0, 0, 3'd0, 9'd383, HB, PB);   // R5 just below threshold
      apply(0, 0, 0, 3'd0, 9'd384, HB, PB);   // R5 threshold
      apply(0, 0, 0, 3'd3, 9'd400, HB, PB);   // R4 guest watchdog
      apply(0, 0, 1, 3'd3, 9'h020, HB, PB);   // R4 does not apply to hyper target
      apply(0, 0, 0, 3'd5, 9'h033, HB, PB);   // R2 level threshold, R6
      apply(1, 1, 0, 3'd0, 9'h033, HB, PB);   // R2 red flag
      apply(0, 1, 1, 3'd6, 9'h044, HB, PB);   // R3 error
      apply(0, 0, 0, 3'd7, 9'h1FF, HB, PB);   // R3 error above max
      apply(1, 0, 0, 3'd7, 9'h044, HB, PB);   // R2 beats R3, R10 cap

      // R11 hold: change inputs without a request, outputs keep old values
      @(negedge clk);
      st_red = 1'b0; cur_tl = 3'd0; trap_tt = 9'h011;
      hyp_base = ~HB; priv_base = ~PB;
      @(negedge clk);
      chk("R11 hold vld", {63'b0, out_vld}, 64'd0);
      chk("R11 hold mode", {62'b0, out_mode}, {62'b0, e_mode});
      chk("R11 hold pc", out_pc, e_pc);

      for (int i = 0; i < 600; i++) begin
         logic [63:0] hb;
         logic [63:0] pb;
         logic [8:0]  tt;
         hb = {$urandom, $urandom};
         pb = {$urandom, $urandom};
         tt = ($urandom_range(0, 1) == 1) ? 9'($urandom_range(370, 400))
                                         : 9'($urandom);
         apply(($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
               3'($urandom_range(0, 7)), tt, hb, pb);
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule